// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block divides a dividend by a divisor over several clock cycles and returns a quotient and a remainder, both of the full operand width. Either operand pair can be treated as unsigned or as two's-complement signed values. Alongside the results it produces three condition flags: zero, negative and overflow. A word-mode select narrows the range in which the quotient counts as valid. When that range is exceeded the overflow flag is raised, but the full-width results are still returned.

A controller pulses `start` with the operands and the two mode selects held valid in that cycle, then waits for `done`. The result registers keep their values until the next completed divide. The quotient is meant to replace the dividend operand and the remainder to replace the divisor operand. A zero divisor does not start a divide. It produces a one-cycle `div0_trap` pulse instead, and the results and flags stay as they were. The division core works on magnitudes with a restoring shift-subtract loop, one quotient bit per cycle, and applies sign correction in a final cycle.

Top module: `idiv_flagged`

## Requirements
- R1: In unsigned mode the quotient is the floor of dividend/divisor and the remainder is dividend minus quotient times divisor, both W bits (default 32).
- R2: In signed mode the quotient is truncated toward zero and the remainder is zero or has the sign of the dividend.
- R3: The most negative dividend divided by all-ones in signed mode gives a quotient with only bit W-1 set and a zero remainder, sets N, does not trap, and sets V when word mode is on.
- R4: A zero divisor with `start` in the idle state pulses `div0_trap` for exactly the cycle after the start cycle. It gives no `done`, and quotient, remainder and flags keep their previous values.
- R5: After a completed divide Z is 1 exactly when the quotient is zero. N is 1 exactly when the quotient is non-zero and its bit W-1 is 1. Z and N are never both 1.
- R6: In unsigned word mode V is 1 exactly when the quotient exceeds 2^HW - 1 (HW defaults to 16).
- R7: In signed word mode V is 1 exactly when the quotient does not fit a sign-extended HW-bit value, that is, when bits W-1 down to HW-1 are not all equal.
- R8: With word mode off, V is 0 after every completed divide.
- R9: `done` is high for exactly one cycle, the (W+1)th cycle after the cycle in which `start` was accepted (W iterations plus one fix-up cycle).
- R10: A `start` that arrives while a divide is in progress is ignored, including one with a zero divisor. The running divide completes with its original operands and no trap is raised.
- R11: After reset, quotient, remainder and all flags are zero and `done` and `div0_trap` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a divide with the operands presented this cycle |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| word_mode | input | 1 | 1: check the quotient against the HW-bit range for V |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| quotient | output | W | Quotient of the last completed divide |
| remainder | output | W | Remainder of the last completed divide |
| flag_z | output | 1 | Quotient is zero |
| flag_n | output | 1 | Quotient is non-zero with its top bit set |
| flag_v | output | 1 | Word-mode quotient out of range |
| div0_trap | output | 1 | One-cycle pulse: divisor was zero |
| done | output | 1 | One-cycle pulse: new results are valid |

## Verification
The bench uses an 8-bit configuration with a 4-bit word range. It sweeps every divisor against a set of dividends that includes the extremes, in both signed and unsigned mode, with word mode alternating. A design that took the sign of the remainder from the divisor, or that rounded the signed quotient toward minus infinity, would disagree on mixed-sign pairs. The most-negative-by-minus-one case catches a design that traps on it, clamps the quotient, or misses V because it checks only the narrow signed range. Zero divisors are given after a valid result: a design that wrote partial results or raised `done` on a trap would show changed outputs. A zero-divisor start is also issued in the middle of a running divide, which shows up a design that restarts or traps while busy.

// File: rtl/idiv_pkg.sv
// Shared types for the iterative divider: controller states and the flag bundle.
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
    } div_flags_t;

endpackage

// File: rtl/idiv_operand_prep.sv
// Operand preparation: turns the dividend and divisor into unsigned magnitudes
// and reports which of them was negative.
// Assumes: in unsigned mode both operands are taken as they are; the most
// negative value maps to magnitude 2^(W-1), which fits W unsigned bits.
module idiv_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         signed_mode,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         dvd_neg,
    output logic         dvs_neg
);

    // Sign detection and conditional two's-complement negation.
    always_comb begin
        dvd_neg = signed_mode & dividend[W-1];
        dvs_neg = signed_mode & divisor[W-1];
        dvd_mag = dvd_neg ? (~dividend + W'(1)) : dividend;
        dvs_mag = dvs_neg ? (~divisor + W'(1)) : divisor;
    end

endmodule

// File: rtl/idiv_restore_step.sv
// One restoring shift-subtract step: shifts the next dividend bit into the
// partial remainder, tries to subtract the divisor, and keeps the difference
// only when it is non-negative. The quotient bit enters at the bottom of the
// shift register that first held the dividend.
// Assumes: part_rem < denom on entry, so the partial remainder fits W bits.
module idiv_restore_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_rem,
    input  logic [W-1:0] part_quo,
    input  logic [W-1:0] denom,
    output logic [W-1:0] next_rem,
    output logic [W-1:0] next_quo
);

    logic [W:0] trial;

    // Trial subtraction and restore decision for one quotient bit.
    always_comb begin
        trial = {part_rem, part_quo[W-1]} - {1'b0, denom};
        if (!trial[W]) begin
            next_rem = trial[W-1:0];
            next_quo = {part_quo[W-2:0], 1'b1};
        end else begin
            next_rem = {part_rem[W-2:0], part_quo[W-1]};
            next_quo = {part_quo[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/idiv_result_fix.sv
// Result fix-up: restores the signs of the quotient and remainder and
// derives the Z, N and V flags from the final quotient.
// Assumes: HW < W. q_neg is the XOR of the operand signs in signed mode and
// r_neg is the dividend sign, so truncation goes toward zero.
module idiv_result_fix
    import idiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         signed_mode,
    input  logic         word_mode,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output div_flags_t   flags
);

    logic upper_used;
    logic sext_fits;

    // Sign restoration of both results.
    always_comb begin
        q_out = q_neg ? (~q_mag + W'(1)) : q_mag;
        r_out = r_neg ? (~r_mag + W'(1)) : r_mag;
    end

    // Range checks of the quotient against the HW-bit word.
    always_comb begin
        upper_used = |q_out[W-1:HW];
        sext_fits  = (&q_out[W-1:HW-1]) | ~(|q_out[W-1:HW-1]);
    end

    // Flag derivation: Z wins over N, V only in word mode.
    always_comb begin
        flags.z = (q_out == '0);
        flags.n = ~flags.z & q_out[W-1];
        flags.v = word_mode & (signed_mode ? ~sext_fits : upper_used);
    end

endmodule

// File: rtl/idiv_flagged.sv
// Iterative divider with condition flags (top level).
// Accepts an operand pair when idle and start is high. A zero divisor gives a
// one-cycle trap and no other change. Otherwise W restoring iterations run on
// magnitudes, followed by a single fix-up cycle that writes the quotient,
// the remainder and the flags and pulses done.
// Assumes: operands and mode selects are valid in the start cycle only;
// start during a running divide is ignored.
module idiv_flagged
    import idiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic         word_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v,
    output logic         div0_trap,
    output logic         done
);

    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST_STEP = CNTW'(W - 1);

    div_state_e     state;
    logic [CNTW-1:0] step_cnt;
    logic [W-1:0]   acc_rem;
    logic [W-1:0]   acc_quo;
    logic [W-1:0]   den_r;
    logic           q_neg_r;
    logic           r_neg_r;
    logic           sm_r;
    logic           wm_r;
    div_flags_t     flags_r;

    logic [W-1:0]   dvd_mag;
    logic [W-1:0]   dvs_mag;
    logic           dvd_neg;
    logic           dvs_neg;
    logic [W-1:0]   step_rem;
    logic [W-1:0]   step_quo;
    logic [W-1:0]   fix_q;
    logic [W-1:0]   fix_r;
    div_flags_t     fix_flags;

    idiv_operand_prep #(.W(W)) u_prep (
        .dividend    (dividend),
        .divisor     (divisor),
        .signed_mode (signed_mode),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .dvd_neg     (dvd_neg),
        .dvs_neg     (dvs_neg)
    );

    idiv_restore_step #(.W(W)) u_step (
        .part_rem (acc_rem),
        .part_quo (acc_quo),
        .denom    (den_r),
        .next_rem (step_rem),
        .next_quo (step_quo)
    );

    idiv_result_fix #(.W(W), .HW(HW)) u_fix (
        .q_mag       (acc_quo),
        .r_mag       (acc_rem),
        .q_neg       (q_neg_r),
        .r_neg       (r_neg_r),
        .signed_mode (sm_r),
        .word_mode   (wm_r),
        .q_out       (fix_q),
        .r_out       (fix_r),
        .flags       (fix_flags)
    );

    // Controller, iteration registers and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step_cnt  <= '0;
            acc_rem   <= '0;
            acc_quo   <= '0;
            den_r     <= '0;
            q_neg_r   <= 1'b0;
            r_neg_r   <= 1'b0;
            sm_r      <= 1'b0;
            wm_r      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            flags_r   <= '0;
            div0_trap <= 1'b0;
            done      <= 1'b0;
        end else begin
            div0_trap <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            div0_trap <= 1'b1;
                        end else begin
                            acc_rem  <= '0;
                            acc_quo  <= dvd_mag;
                            den_r    <= dvs_mag;
                            q_neg_r  <= dvd_neg ^ dvs_neg;
                            r_neg_r  <= dvd_neg;
                            sm_r     <= signed_mode;
                            wm_r     <= word_mode;
                            step_cnt <= '0;
                            state    <= ST_ITER;
                        end
                    end
                end
                ST_ITER: begin
                    acc_rem  <= step_rem;
                    acc_quo  <= step_quo;
                    step_cnt <= step_cnt + CNTW'(1);
                    if (step_cnt == LAST_STEP) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    quotient  <= fix_q;
                    remainder <= fix_r;
                    flags_r   <= fix_flags;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Flag outputs taken from the registered bundle.
    always_comb begin
        flag_z = flags_r.z;
        flag_n = flags_r.n;
        flag_v = flags_r.v;
    end

endmodule

// File: rtl/idiv_flagged_chk.sv
// Assertion checker for idiv_flagged, attached with bind below.
// Keeps its own model of when a divide was accepted so that the latency and
// the word-mode setting can be checked from the ports alone.
module idiv_flagged_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         word_mode,
    input logic [W-1:0] divisor,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_v,
    input logic         div0_trap,
    input logic         done
);

    localparam int LAT = W + 1;
    localparam int CW  = $clog2(W + 2) + 1;

    logic          c_run;
    logic [CW-1:0] c_cnt;
    logic          c_word;

    // Shadow tracking of an accepted divide and the cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_run  <= 1'b0;
            c_cnt  <= '0;
            c_word <= 1'b0;
        end else if (c_run && !done) begin
            c_cnt <= c_cnt + CW'(1);
        end else if (start && (divisor != '0)) begin
            c_run  <= 1'b1;
            c_cnt  <= '0;
            c_word <= word_mode;
        end else begin
            c_run <= 1'b0;
        end
    end

    assert_trap_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div0_trap |-> ($stable(quotient) && $stable(remainder) &&
                       $stable(flag_z) && $stable(flag_n) && $stable(flag_v)));

    assert_trap_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(div0_trap && done));

    assert_trap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div0_trap |-> ($past(start) && ($past(divisor) == '0)));

    assert_zn_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_z && flag_n));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (quotient == '0)));

    assert_no_v_outside_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !c_word) |-> !flag_v);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c_run && (c_cnt == CW'(LAT))));

endmodule

bind idiv_flagged idiv_flagged_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word_mode (word_mode),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .div0_trap (div0_trap),
    .done      (done)
);

// File: tb/idiv_flagged_test.sv
// Self-checking bench: 8-bit divider with a 4-bit word range, swept over
// every divisor against a set of dividends in both sign modes.
module idiv_flagged_test;

    localparam int W  = 8;
    localparam int HW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic         word_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         flag_z;
    logic         flag_n;
    logic         flag_v;
    logic         div0_trap;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    idiv_flagged #(.W(W), .HW(HW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .word_mode   (word_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .flag_z      (flag_z),
        .flag_n      (flag_n),
        .flag_v      (flag_v),
        .div0_trap   (div0_trap),
        .done        (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick_dvd(input int i);
        case (i)
            16:      return 8'h80;
            17:      return 8'h7F;
            18:      return 8'h81;
            19:      return 8'h01;
            default: return W'(i * 17);
        endcase
    endfunction

    // Runs one divide from a negedge and checks all results against arithmetic.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sg, input logic wd);
        logic signed [W-1:0] as_s;
        logic signed [W-1:0] bs_s;
        int ai, bi, qi, ri, n;
        logic [W-1:0] eq, er;
        logic ez, en, ev;
        logic [W-1:0] pq, pr;
        logic [2:0] pf;
        string qtag, vtag;
        as_s = a;
        bs_s = b;
        ai = sg ? int'(as_s) : int'(a);
        bi = sg ? int'(bs_s) : int'(b);
        pq = quotient;
        pr = remainder;
        pf = {flag_z, flag_n, flag_v};
        dividend = a;
        divisor = b;
        signed_mode = sg;
        word_mode = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (b == '0) begin
            chk(div0_trap && !done, "R4 trap pulse", {div0_trap, done}, 2'b10);
            for (int k = 0; k < W + 3; k++) begin
                @(negedge clk);
                chk(!done && !div0_trap, "R4 no done or repeat trap", {div0_trap, done}, 0);
            end
            chk({quotient, remainder, flag_z, flag_n, flag_v} == {pq, pr, pf},
                "R4 outputs unchanged", {quotient, remainder}, {pq, pr});
        end else begin
            qi = ai / bi;
            ri = ai % bi;
            eq = qi[W-1:0];
            er = ri[W-1:0];
            ez = (eq == '0);
            en = !ez && eq[W-1];
            ev = wd && (sg ? (qi > (2 ** (HW - 1)) - 1 || qi < -(2 ** (HW - 1)))
                           : (qi > (2 ** HW) - 1));
            chk(!div0_trap, "R4 no trap on non-zero divisor", div0_trap, 0);
            n = 0;
            while (!done && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == W + 1, "R9 done latency", n, W + 1);
            if (sg && a == 8'h80 && b == 8'hFF) qtag = "R3 min/-1 result";
            else if (sg) qtag = "R2 signed quotient/remainder";
            else qtag = "R1 unsigned quotient/remainder";
            chk({quotient, remainder} == {eq, er}, qtag, {quotient, remainder}, {eq, er});
            chk({flag_z, flag_n} == {ez, en}, "R5 Z/N flags", {flag_z, flag_n}, {ez, en});
            if (!wd) vtag = "R8 V off outside word mode";
            else if (sg) vtag = "R7 signed word V";
            else vtag = "R6 unsigned word V";
            chk(flag_v == ev, vtag, flag_v, ev);
            @(negedge clk);
            chk(!done, "R9 done one cycle", done, 0);
        end
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk({quotient, remainder, flag_z, flag_n, flag_v, div0_trap, done} == '0,
            "R11 reset state", {quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({quotient, remainder, flag_z, flag_n, flag_v, div0_trap, done} == '0,
            "R11 state after release", {quotient, remainder}, 0);

        // R3: most negative over minus one, word mode on and off.
        run_div(8'h80, 8'hFF, 1'b1, 1'b1);
        run_div(8'h80, 8'hFF, 1'b1, 1'b0);

        // R4: trap after a valid result must leave it in place.
        run_div(8'd100, 8'd7, 1'b0, 1'b0);
        run_div(8'd55, 8'd0, 1'b0, 1'b0);
        run_div(8'h90, 8'd0, 1'b1, 1'b1);

        // R10: start with a zero divisor while busy is ignored.
        dividend = 8'd200;
        divisor = 8'd3;
        signed_mode = 1'b0;
        word_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        repeat (3) begin
            @(negedge clk);
            n++;
        end
        dividend = 8'd9;
        divisor = 8'd0;
        start = 1'b1;
        @(negedge clk);
        n++;
        start = 1'b0;
        chk(!div0_trap, "R10 no trap while busy", div0_trap, 0);
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == W + 1, "R10 latency kept from first start", n, W + 1);
        chk({quotient, remainder} == {8'd66, 8'd2}, "R10 original operands used",
            {quotient, remainder}, {8'd66, 8'd2});
        @(negedge clk);

        // Sweep: every divisor against the dividend set, both sign modes.
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 20; i++) begin
                for (int j = 0; j < 256; j++) begin
                    run_div(pick_dvd(i), W'(j), s[0], 1'((i + j) & 1));
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule